// File: doc/BRIEF.md
# Early-Late Gate Symbol Timing Recovery and Bit Detector

This block recovers the symbol timing of a binary stream carried by a signed decision metric. The metric is positive while a 1 is being sent and negative while a 0 is being sent. Every symbol spans a fixed number of metric samples. The block runs an assumed symbol clock from a phase counter. It integrates the metric over the first half of each assumed symbol (the early gate) and over the second half (the late gate). It compares the absolute values of the two gate averages. From the size and the sign of that difference it pulls the phase of the assumed clock forward or back, once per symbol. Over the same recovered symbol it also sums the metric and decides the bit from the sign of the total.

The block sits after the demodulator that produces the metric, and it is fed one sample per asserted `in_vld`. The default symbol is 8192 samples, made of two halves of 4096. The phase counter is short, so all averaging is done with shifts, and the correction step is a shifted magnitude. When a forward correction is large, a guard keeps any half from ending before half of its nominal length has passed.

Top module: `elsync_top`

## Requirements
- R1: While reset is asserted and right after it, `sym_clk` is 1, and `bit_vld`, `bit_out` and `locked` are 0. The first recovered symbol begins with the first valid sample after reset.
- R2: Only cycles with `in_vld` high advance the block, and the metric is ignored in all other cycles. With a zero correction, each half of `sym_clk` lasts 2^HALF_W valid samples, so a symbol lasts 2^(HALF_W+1). `sym_clk` is 1 during the early half and 0 during the late half.
- R3: Each gate sums the metric times 8 over its half. The sum is divided by 2^HALF_W with an arithmetic shift that rounds toward minus infinity. Call the results E and L, and let D = |E| - |L|. The correction magnitude is |D| >> STEP_SHR, capped at 2^HALF_W - 1, and it takes the sign of D. When D is 0, as with equal gates, the correction is zero.
- R4: The correction acts on the early half that follows a symbol end. A negative correction c makes that early half last 2^HALF_W - c samples. A positive correction c makes it last 2^HALF_W - c samples, but never fewer than 2^(HALF_W-1).
- R5: The bit decision is 1 exactly when the metric summed over the whole recovered symbol is greater than zero. A sum of zero or below gives 0.
- R6: `bit_vld` is high for exactly one cycle. That cycle is the one after the clock edge that takes the last valid sample of a symbol, and `sym_clk` rises at that same edge. `bit_out` holds the decision for that symbol.
- R7: The gate accumulators and the decision accumulator saturate at their signed limits and never wrap. A long, full-scale positive symbol still decides 1.
- R8: `locked` is 1 once the last four symbol corrections have all been zero. It drops to 0 at the first symbol end with a nonzero correction, and it changes only at symbol ends.
- R9: For an alternating bit pattern that starts a fraction of a symbol away from the assumed timing, the corrections pull the assumed clock into line. After that the decisions alternate, the symbol length returns to nominal, and `locked` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Metric sample strobe |
| in_metric | input | IN_W | Signed decision metric sample |
| sym_clk | output | 1 | Recovered symbol clock, 1 in the early half |
| locked | output | 1 | Phase correction has settled |
| bit_out | output | 1 | Detected bit of the last symbol |
| bit_vld | output | 1 | One-cycle strobe at each symbol end |

## Verification
The properties assume that `in_vld` may drop at any cycle, and they assume nothing about the metric. They only assume that `sym_clk` and `bit_vld` come from the same edges as the sample strobe. The guard property counts accepted samples per half. This count holds because the stimulus only ever advances the block through `in_vld`, including the gapped random phase, where garbage metric values are presented while `in_vld` is low. The directed stimulus keeps each metric inside the signed input range and builds the gate patterns on purpose. Those patterns produce the largest retard, the largest advance and accumulator saturation. The random phase keeps each symbol's amplitude constant, so the gates stay equal and the symbol boundaries can be predicted.

// File: rtl/esync_pkg.sv
package esync_pkg;

    // which gate of the assumed symbol is being integrated
    typedef enum logic {
        HALF_LATE  = 1'b0,
        HALF_EARLY = 1'b1
    } half_e;

    // registered decision presented at the outputs
    typedef struct packed {
        logic vld;
        logic value;
    } decision_t;

    function automatic logic [31:0] umin32(logic [31:0] a, logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/esync_integ.sv
// Saturating accumulator over a window; total includes the current sample.
module esync_integ #(
    parameter int IN_W   = 17,
    parameter int ACC_W  = 29,
    parameter int AVG_SH = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            en,
    input  logic                            dump,
    input  logic signed [IN_W-1:0]          din,
    output logic signed [ACC_W-AVG_SH-1:0]  avg
);
    localparam logic signed [ACC_W:0] SMAX = (ACC_W+1)'({1'b0, {(ACC_W-1){1'b1}}});
    localparam logic signed [ACC_W:0] SMIN = -SMAX - 1;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W:0]   addend;
    logic signed [ACC_W:0]   wide;

    always_comb begin
        addend = en ? (ACC_W+1)'(din) : (ACC_W+1)'(0);
        wide   = (ACC_W+1)'(acc) + addend;
        if (wide > SMAX)
            total = SMAX[ACC_W-1:0];
        else if (wide < SMIN)
            total = SMIN[ACC_W-1:0];
        else
            total = wide[ACC_W-1:0];
    end

    assign avg = total[ACC_W-1:AVG_SH];

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (en)
            acc <= dump ? '0 : total;
    end
endmodule

// File: rtl/esync_phase.sv
// Assumed symbol clock: half counter with a loadable start and an early-toggle guard.
module esync_phase
    import esync_pkg::*;
#(
    parameter int HALF_W = 12,
    localparam int CNT_W = HALF_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld,
    input  logic signed [CNT_W-1:0] load,
    output half_e                   half,
    output logic                    half_end,
    output logic                    sym_end
);
    localparam int GUARD_W   = HALF_W + 1;
    localparam int HALF_MAX  = (1 << HALF_W) - 1;
    localparam int GUARD_MIN = 1 << (HALF_W - 1);
    localparam logic signed [CNT_W-1:0] TOP = CNT_W'(HALF_MAX);
    localparam logic [GUARD_W-1:0] GLIM = GUARD_W'(GUARD_MIN - 1);

    logic signed [CNT_W-1:0] cnt;
    logic [GUARD_W-1:0]      gcnt;
    logic                    at_top;
    logic                    guard_ok;

    assign at_top   = (cnt >= TOP);
    assign guard_ok = (gcnt >= GLIM);
    assign half_end = vld && at_top && guard_ok;
    assign sym_end  = half_end && (half == HALF_LATE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            gcnt <= '0;
            half <= HALF_EARLY;
        end else if (vld) begin
            if (half_end) begin
                half <= (half == HALF_EARLY) ? HALF_LATE : HALF_EARLY;
                cnt  <= (half == HALF_EARLY) ? '0 : load;
                gcnt <= '0;
            end else begin
                if (!at_top)
                    cnt <= cnt + 1'b1;
                if (gcnt != '1)
                    gcnt <= gcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/esync_ted.sv
// Timing error: magnitude from |E|-|L|, direction from its sign, scaled and capped.
module esync_ted
    import esync_pkg::*;
#(
    parameter int G_W      = 17,
    parameter int HALF_W   = 12,
    parameter int STEP_SHR = 6,
    localparam int CNT_W   = HALF_W + 2
) (
    input  logic signed [G_W-1:0]   e_val,
    input  logic signed [G_W-1:0]   l_val,
    output logic signed [CNT_W-1:0] step
);
    localparam int HALF_MAX = (1 << HALF_W) - 1;

    logic signed [G_W:0]   ex, lx, ea, la;
    logic signed [G_W+1:0] diff;
    logic [G_W+1:0]        dmag, shifted;
    logic [CNT_W-1:0]      mc;

    always_comb begin
        ex      = (G_W+1)'(e_val);
        lx      = (G_W+1)'(l_val);
        ea      = (ex < 0) ? -ex : ex;
        la      = (lx < 0) ? -lx : lx;
        diff    = (G_W+2)'(ea) - (G_W+2)'(la);
        dmag    = (diff < 0) ? $unsigned(-diff) : $unsigned(diff);
        shifted = dmag >> STEP_SHR;
        mc      = CNT_W'(umin32(32'(shifted), 32'(HALF_MAX)));
        step    = (diff < 0) ? -$signed(mc) : $signed(mc);
    end
endmodule

// File: rtl/elsync_top.sv
module elsync_top
    import esync_pkg::*;
#(
    parameter int IN_W     = 14,
    parameter int HALF_W   = 12,
    parameter int PRE_SHL  = 3,
    parameter int STEP_SHR = 6,
    parameter int LOCK_N   = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic signed [IN_W-1:0] in_metric,
    output logic                   sym_clk,
    output logic                   locked,
    output logic                   bit_out,
    output logic                   bit_vld
);
    localparam int SH_W  = IN_W + PRE_SHL;
    localparam int ACC_W = SH_W + HALF_W;
    localparam int DEC_W = ACC_W + 1;
    localparam int G_W   = SH_W;
    localparam int CNT_W = HALF_W + 2;
    localparam int LK_W  = $clog2(LOCK_N + 1);

    logic signed [SH_W-1:0]  scaled;
    half_e                   half;
    logic                    half_end, sym_end;
    logic signed [CNT_W-1:0] step;
    logic signed [G_W-1:0]   gate_avg [2];
    logic signed [G_W-1:0]   e_reg;
    logic signed [DEC_W-1:0] dec_sum;
    logic [LK_W-1:0]         lk_cnt;
    decision_t               dec_q;

    assign scaled = SH_W'(in_metric) <<< PRE_SHL;

    esync_phase #(.HALF_W(HALF_W)) u_phase (
        .clk(clk), .rst(rst), .vld(in_vld), .load(step),
        .half(half), .half_end(half_end), .sym_end(sym_end)
    );

    // index 1 = early gate, index 0 = late gate
    for (genvar g = 0; g < 2; g++) begin : g_gate
        logic gate_en;
        assign gate_en = in_vld && ((half == HALF_EARLY) == (g == 1));
        esync_integ #(.IN_W(SH_W), .ACC_W(ACC_W), .AVG_SH(HALF_W)) u_int (
            .clk(clk), .rst(rst), .en(gate_en), .dump(half_end),
            .din(scaled), .avg(gate_avg[g])
        );
    end

    esync_integ #(.IN_W(SH_W), .ACC_W(DEC_W), .AVG_SH(0)) u_dec (
        .clk(clk), .rst(rst), .en(in_vld), .dump(sym_end),
        .din(scaled), .avg(dec_sum)
    );

    esync_ted #(.G_W(G_W), .HALF_W(HALF_W), .STEP_SHR(STEP_SHR)) u_ted (
        .e_val(e_reg), .l_val(gate_avg[0]), .step(step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            e_reg  <= '0;
            dec_q  <= '0;
            lk_cnt <= '0;
        end else begin
            dec_q.vld <= sym_end;
            if (half_end && (half == HALF_EARLY))
                e_reg <= gate_avg[1];
            if (sym_end) begin
                dec_q.value <= !dec_sum[DEC_W-1] && (dec_sum != '0);
                if (step != '0)
                    lk_cnt <= '0;
                else if (lk_cnt != LK_W'(LOCK_N))
                    lk_cnt <= lk_cnt + 1'b1;
            end
        end
    end

    assign sym_clk = (half == HALF_EARLY);
    assign bit_out = dec_q.value;
    assign bit_vld = dec_q.vld;
    assign locked  = (lk_cnt >= LK_W'(LOCK_N));
endmodule

// File: rtl/esync_chk.sv
module esync_chk #(
    parameter int HALF_W = 12
) (
    input logic clk,
    input logic rst,
    input logic in_vld,
    input logic sym_clk,
    input logic locked,
    input logic bit_vld
);
    localparam int unsigned GUARD_MIN = 1 << (HALF_W - 1);

    logic        sym_q;
    int unsigned hcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q <= 1'b1;
            hcnt  <= 0;
        end else begin
            sym_q <= sym_clk;
            if (sym_clk != sym_q)
                hcnt <= in_vld ? 1 : 0;
            else if (in_vld)
                hcnt <= hcnt + 1;
        end
    end

    // R6
    bv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> !bit_vld);

    // R6
    bv_edge_chk: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> (sym_clk && !$past(sym_clk)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_vld) |-> $stable(sym_clk));

    // R4
    guard_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_clk != sym_q) |-> (hcnt >= GUARD_MIN));

    // R8
    lock_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(locked) |-> bit_vld);
endmodule

bind elsync_top esync_chk #(.HALF_W(HALF_W)) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .sym_clk(sym_clk),
    .locked(locked), .bit_vld(bit_vld)
);

// File: tb/sim_elsync_top.sv
module sim_elsync_top;
    localparam int PERIOD   = 10;
    localparam int HALF_W   = 6;
    localparam int HALF     = 1 << HALF_W;
    localparam int SYM      = 2 * HALF;
    localparam int STEP_SHR = 6;
    localparam int FULL     = 8191;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic signed [13:0] in_metric = '0;
    logic sym_clk, locked, bit_out, bit_vld;

    elsync_top #(.IN_W(14), .HALF_W(HALF_W), .PRE_SHL(3), .STEP_SHR(STEP_SHR), .LOCK_N(4)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_metric(in_metric),
        .sym_clk(sym_clk), .locked(locked), .bit_out(bit_out), .bit_vld(bit_vld)
    );

    always #(PERIOD/2) clk = ~clk;

    int nchk = 0, nerr = 0;
    int vcount, nobs, fall_at;
    int obs_bnd [0:63];
    logic obs_bit [0:63];
    logic obs_lk [0:63];
    logic prev_sym, prev_bv;
    logic expb [0:63];

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    // expected correction per R3
    function automatic int ref_step(int e, int l);
        int d = iabs(e) - iabs(l);
        int m = iabs(d) >> STEP_SHR;
        if (m > HALF - 1) m = HALF - 1;
        return (d < 0) ? -m : m;
    endfunction

    // expected early-half length per R4
    function automatic int ref_early(int st);
        int n = HALF - st;
        return (n < HALF / 2) ? HALF / 2 : n;
    endfunction

    function automatic logic ref_bit(longint sum);
        return sum > 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input int m);
        @(negedge clk);
        if (bit_vld) begin
            if (nobs < 64) begin
                obs_bnd[nobs] = vcount;
                obs_bit[nobs] = bit_out;
                obs_lk[nobs]  = locked;
            end
            nobs++;
            chk(!prev_bv, "R6 strobe width", 1, 0);
            chk(sym_clk && !prev_sym, "R6 strobe with sym_clk rise", int'(sym_clk), 1);
        end
        if (prev_sym && !sym_clk) fall_at = vcount;
        prev_bv  = bit_vld;
        prev_sym = sym_clk;
        in_vld    = v;
        in_metric = 14'(m);
        if (v) vcount++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk(sym_clk == 1'b1 && bit_vld == 1'b0 && locked == 1'b0 && bit_out == 1'b0,
            "R1 reset state", {sym_clk, bit_vld, locked, bit_out}, 4'b1000);
        rst = 1'b0;
        vcount = 0; nobs = 0; fall_at = -1;
        prev_sym = 1'b1; prev_bv = 1'b0;
    endtask

    task automatic flush();
        repeat (4) step(1'b0, 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));

        // Scenario A: aligned random bits, gapped strobe, garbage on idle cycles
        do_reset();
        for (int k = 0; k < 10; k++) begin
            int b   = $urandom % 2;
            int amp = 1 + ($urandom % 4000);
            int val;
            if (k == 5) amp = 0;
            val = (b != 0) ? amp : -amp;
            expb[k] = ref_bit(longint'(val) * SYM);
            for (int i = 0; i < SYM; i++) begin
                while (($urandom % 4) == 0) step(1'b0, int'($urandom % 16384) - 8192);
                step(1'b1, val);
            end
        end
        flush();
        chk(nobs == 10, "R6 symbol count", nobs, 10);
        for (int k = 0; k < 10; k++) begin
            // R5 (k=5 is a zero-sum symbol), R2 nominal period with idle gaps
            chk(obs_bit[k] == expb[k], "R5 decision", int'(obs_bit[k]), int'(expb[k]));
            chk(obs_bnd[k] == SYM * (k + 1), "R2 symbol boundary", obs_bnd[k], SYM * (k + 1));
            chk(obs_lk[k] == (k >= 3), "R8 locked after four zero corrections",
                int'(obs_lk[k]), int'(k >= 3));
        end

        // Scenario B: largest retard, saturation, largest advance with guard
        do_reset();
        begin
            int e0 = 0;
            int l0 = (FULL * 8 * HALF) >>> HALF_W;
            int st0 = ref_step(e0, l0);
            int len1 = ref_early(st0) + HALF;
            int b1_end;
            int e2 = (FULL * 8 * HALF) >>> HALF_W;
            int st2 = ref_step(e2, 0);
            int e3len = ref_early(st2);
            for (int i = 0; i < HALF; i++) step(1'b1, 0);
            for (int i = 0; i < HALF; i++) step(1'b1, FULL);
            for (int i = 0; i < len1; i++) step(1'b1, FULL);
            for (int i = 0; i < HALF; i++) step(1'b1, FULL);
            for (int i = 0; i < HALF; i++) step(1'b1, 0);
            for (int i = 0; i < e3len + HALF; i++) step(1'b1, 0);
            flush();
            b1_end = SYM + len1;
            chk(nobs == 4, "R4 symbol count", nobs, 4);
            chk(obs_bit[0] == 1'b1, "R5 late-only symbol", int'(obs_bit[0]), 1);
            // R3 negative correction lengthens the next early half
            chk(obs_bnd[1] == b1_end, "R3 retard length", obs_bnd[1], b1_end);
            chk(obs_bit[1] == 1'b1, "R7 saturated decision", int'(obs_bit[1]), 1);
            chk(obs_bnd[2] == b1_end + SYM, "R3 zero correction", obs_bnd[2], b1_end + SYM);
            chk(fall_at == b1_end + SYM + HALF / 2, "R4 guard on forward jump",
                fall_at - (b1_end + SYM), HALF / 2);
            chk(obs_bnd[3] == b1_end + SYM + e3len + HALF, "R4 advance length",
                obs_bnd[3], b1_end + SYM + e3len + HALF);
            chk(obs_bit[3] == 1'b0, "R5 zero sum gives 0", int'(obs_bit[3]), 0);
            chk(obs_lk[3] == 1'b0, "R8 not locked", int'(obs_lk[3]), 0);
        end

        // Scenario C: alternating bits offset from the assumed timing
        do_reset();
        for (int i = 0; i < 24; i++) step(1'b1, -128);
        for (int k = 0; k < 40; k++)
            for (int i = 0; i < SYM; i++) step(1'b1, (k % 2 == 0) ? 128 : -128);
        flush();
        chk(nobs >= 38, "R9 symbols seen", nobs, 38);
        chk(obs_lk[0] == 1'b0, "R8 unlocked while correcting", int'(obs_lk[0]), 0);
        chk(obs_bnd[0] == SYM, "R9 first boundary", obs_bnd[0], SYM);
        chk(obs_lk[nobs-1] == 1'b1, "R9 locked at end", int'(obs_lk[nobs-1]), 1);
        chk(obs_bnd[nobs-1] - obs_bnd[nobs-2] == SYM, "R9 nominal period",
            obs_bnd[nobs-1] - obs_bnd[nobs-2], SYM);
        for (int k = nobs - 8; k < nobs; k++)
            chk(obs_bit[k] != obs_bit[k-1], "R9 alternating decisions",
                int'(obs_bit[k]), int'(!obs_bit[k-1]));

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule